// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block sequences I2C master transfers. Software writes a 16-bit control word, a byte count and a 7-bit target address. The sequencer then steps a byte-level bus engine through a start with the address, a series of byte sends or byte receives, and a stop. The bit-level SCL and SDA timing belongs to the engine. Each engine command is held valid until the engine returns a one-cycle done strobe, together with an acknowledge bit and, for reads, a received byte.

A transmit buffer feeds outgoing bytes, and a receive buffer collects incoming bytes. A working counter tracks how many bytes remain. Status outputs report a failed acknowledge, the end of an access, and whether the buffers need service. In the repeating mode the counter plays no part, and the transfer runs until software requests a stop.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write stores `ctl_wdata & 16'hCF87`. Bit 15 is enable, bit 10 is master, bit 9 is transmit, bit 2 is repeat, bit 1 is stop and bit 0 is start.
- R2: While enabled, the start bit issues a START command (`cmd_op`=0) carrying `tgt_addr`, with `cmd_rnw` equal to the inverse of bit 9. An enabled start write reloads the working count from the programmed count and clears both flags. The start bit self-clears when START completes.
- R3: If the address is not acknowledged, `nack_flag` is set and the stop bit clears. No data command follows, no STOP command follows, and the bus is not held busy.
- R4: In transmit mode a SEND (`cmd_op`=1) takes the oldest buffered byte. A SEND is issued only while the count is nonzero and a byte is buffered, and each completed SEND or RECV decrements the count.
- R5: Outside repeat mode, a zero count sets `ardy_flag` and clears the master bit. If the stop bit is then set, a STOP (`cmd_op`=3) is issued, and when it completes the stop bit clears and the count reloads.
- R6: In receive mode a RECV (`cmd_op`=2) is issued only while the count is nonzero and fewer than RX_DEPTH (4) bytes are held. Bytes come out in arrival order, and `rrdy` is high whenever a byte is held.
- R7: In repeat mode the count is neither tested nor decremented. A set stop bit issues STOP before any further data command.
- R8: A SEND completing without acknowledge sets `nack_flag`, and no further SEND is issued.
- R9: While the enable bit is 0, `cmd_valid` is low, `bus_busy` is low, and engine done strobes change nothing. A control write with enable 0 empties both buffers.
- R10: `xrdy` is high exactly when the bus is held, transmit is selected, no NACK is flagged, the count is nonzero or repeat mode is on, and the transmit buffer has room.
- R11: After reset the control word, flags, count and buffers are zero and `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| cnt_wr | input | 1 | Programmed count write strobe |
| cnt_wdata | input | CNT_W | Programmed count value |
| tgt_addr | input | ADDR_W | Target device address |
| tx_push | input | 1 | Push one byte into the transmit buffer |
| tx_byte | input | DATA_W | Byte to push |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_byte | output | DATA_W | Oldest received byte |
| ctrl_q | output | 16 | Current control word |
| work_cnt | output | CNT_W | Working byte count |
| nack_flag | output | 1 | Acknowledge failure seen |
| ardy_flag | output | 1 | Access complete |
| xrdy | output | 1 | Transmit buffer needs data |
| rrdy | output | 1 | Receive buffer holds data |
| bus_busy | output | 1 | Bus held between start and stop |
| cmd_valid | output | 1 | Engine command pending |
| cmd_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| cmd_addr | output | ADDR_W | Address for start |
| cmd_rnw | output | 1 | Read direction for start |
| cmd_data | output | DATA_W | Byte for send |
| eng_done | input | 1 | Engine completion strobe |
| eng_ack | input | 1 | Acknowledge result with done |
| eng_rdata | input | DATA_W | Received byte with done |

## Verification
A control write is visible on `ctrl_q` one edge after its strobe. An enabled start raises `cmd_valid` one edge later. Each done strobe updates the flags, the count and the buffers at the same edge that returns the sequencer to idle, and the next command follows one edge after that. The bench therefore drives on falling edges and samples on falling edges. After a command it waits until the start and stop bits have cleared, or for a fixed cycle budget that covers the engine model's three-cycle latency. It then compares the engine-side command log and the status outputs with values worked out from the requirements.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   localparam int CB_EN  = 15;
   localparam int CB_MST = 10;
   localparam int CB_TRX = 9;
   localparam int CB_RPT = 2;
   localparam int CB_STP = 1;
   localparam int CB_STT = 0;
   localparam logic [15:0] CTRL_KEEP = 16'hCF87;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_SEND  = 2'd1,
      OP_RECV  = 2'd2,
      OP_STOP  = 2'd3
   } bus_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_SEND,
      S_RECV,
      S_STOP
   } seq_st_e;
endpackage

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int LW = $clog2(DEPTH + 1);
   localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

   logic [LW-1:0] level_q;
   logic          do_push, do_pop;

   initial begin
      if (DEPTH < 1) $fatal(1, "i2cs_fifo: DEPTH must be at least 1");
      if (W < 1)     $fatal(1, "i2cs_fifo: W must be at least 1");
   end

   assign empty   = (level_q == '0);
   assign full    = (level_q == LVL_MAX);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);

   always_ff @(posedge clk) begin
      if (!rst_n || flush)
         level_q <= '0;
      else if (do_push && !do_pop)
         level_q <= level_q + LW'(1);
      else if (do_pop && !do_push)
         level_q <= level_q - LW'(1);
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               hold_q <= '0;
            else if (do_push)
               hold_q <= din;
         end
         assign dout = hold_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] wr_q, rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
               wr_q <= '0;
               rd_q <= '0;
            end else begin
               if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + PW'(1);
               if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + PW'(1);
            end
         end
         always_ff @(posedge clk) begin
            if (do_push) mem_q[wr_q] <= din;
         end
         assign dout = empty ? '0 : mem_q[rd_q];
      end
   endgenerate

   AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LVL_MAX); // R6
endmodule

// File: rtl/i2cs_counter.sv
module i2cs_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prog_wr,
   input  logic [CNT_W-1:0] prog_val,
   input  logic             load,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt_q,
   output logic             zero
);
   logic [CNT_W-1:0] prog_q;

   initial begin
      if (CNT_W < 1) $fatal(1, "i2cs_counter: CNT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         prog_q <= '0;
      else if (prog_wr)
         prog_q <= prog_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= prog_q;
      else if (dec)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero = (cnt_q == '0);

   AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/i2cs_seq_fsm.sv
module i2cs_seq_fsm
   import i2cs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_wr,
   input  logic [15:0] ctl_wdata,
   input  logic        cnt_zero,
   input  logic        tx_empty,
   input  logic        rx_full,
   input  logic        eng_done,
   input  logic        eng_ack,
   output logic [15:0] ctrl_q,
   output logic        cmd_valid,
   output logic [1:0]  cmd_op,
   output logic        cnt_load,
   output logic        cnt_dec,
   output logic        tx_pop,
   output logic        rx_push,
   output logic        flush,
   output logic        nack_q,
   output logic        ardy_q,
   output logic        busy_q
);
   seq_st_e     state_q, state_n;
   logic [15:0] ctrl_n;
   logic        nack_n, ardy_n, busy_n;
   logic        en, rpt, trx, stp;

   assign en  = ctrl_q[CB_EN];
   assign rpt = ctrl_q[CB_RPT];
   assign trx = ctrl_q[CB_TRX];
   assign stp = ctrl_q[CB_STP];

   assign flush = ctl_wr && !ctl_wdata[CB_EN];

   always_comb begin
      state_n  = state_q;
      ctrl_n   = ctrl_q;
      nack_n   = nack_q;
      ardy_n   = ardy_q;
      busy_n   = busy_q;
      cnt_load = 1'b0;
      cnt_dec  = 1'b0;
      tx_pop   = 1'b0;
      rx_push  = 1'b0;
      if (!en) begin
         state_n = S_IDLE;
         busy_n  = 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (ctrl_q[CB_STT]) begin
                  state_n = S_START;
               end else if (busy_q) begin
                  if (rpt) begin
                     if (stp)                              state_n = S_STOP;
                     else if (trx && !nack_q && !tx_empty) state_n = S_SEND;
                     else if (!trx && !rx_full)            state_n = S_RECV;
                  end else begin
                     if (cnt_zero && ctrl_q[CB_MST]) begin
                        ardy_n         = 1'b1;
                        ctrl_n[CB_MST] = 1'b0;
                     end
                     if ((cnt_zero || nack_q) && stp)
                        state_n = S_STOP;
                     else if (!cnt_zero && trx && !nack_q && !tx_empty)
                        state_n = S_SEND;
                     else if (!cnt_zero && !trx && !rx_full)
                        state_n = S_RECV;
                  end
               end
            end
            S_START: if (eng_done) begin
               ctrl_n[CB_STT] = 1'b0;
               state_n        = S_IDLE;
               if (eng_ack) begin
                  busy_n = 1'b1;
               end else begin
                  nack_n         = 1'b1;
                  busy_n         = 1'b0;
                  ctrl_n[CB_STP] = 1'b0;
               end
            end
            S_SEND: if (eng_done) begin
               tx_pop  = 1'b1;
               cnt_dec = !rpt && !cnt_zero;
               if (!eng_ack) nack_n = 1'b1;
               state_n = S_IDLE;
            end
            S_RECV: if (eng_done) begin
               rx_push = 1'b1;
               cnt_dec = !rpt && !cnt_zero;
               state_n = S_IDLE;
            end
            S_STOP: if (eng_done) begin
               busy_n         = 1'b0;
               ctrl_n[CB_STP] = 1'b0;
               cnt_load       = 1'b1;
               state_n        = S_IDLE;
            end
            default: state_n = S_IDLE;
         endcase
      end
      if (ctl_wr) begin
         ctrl_n = ctl_wdata & CTRL_KEEP;
         if (ctl_wdata[CB_EN] && ctl_wdata[CB_STT]) begin
            cnt_load = 1'b1;
            nack_n   = 1'b0;
            ardy_n   = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         ctrl_q  <= '0;
         nack_q  <= 1'b0;
         ardy_q  <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         state_q <= state_n;
         ctrl_q  <= ctrl_n;
         nack_q  <= nack_n;
         ardy_q  <= ardy_n;
         busy_q  <= busy_n;
      end
   end

   assign cmd_valid = en && (state_q != S_IDLE);
   always_comb begin
      unique case (state_q)
         S_SEND:  cmd_op = OP_SEND;
         S_RECV:  cmd_op = OP_RECV;
         S_STOP:  cmd_op = OP_STOP;
         default: cmd_op = OP_START;
      endcase
   end

   AST_NO_SEND_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      nack_q |-> (state_q != S_SEND)); // R8
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state_q == S_IDLE) && !busy_q); // R9
   AST_STT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state_q == S_START && eng_done && !ctl_wr) |=> !ctrl_q[CB_STT]); // R2
   AST_ARDY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ardy_q) |-> $past(cnt_zero)); // R5
   AST_DATA_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_SEND || state_q == S_RECV) |-> busy_q); // R4
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
   import i2cs_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 8,
   parameter int TX_DEPTH = 4,
   parameter int RX_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [15:0]       ctl_wdata,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_byte,
   output logic [15:0]       ctrl_q,
   output logic [CNT_W-1:0]  work_cnt,
   output logic              nack_flag,
   output logic              ardy_flag,
   output logic              xrdy,
   output logic              rrdy,
   output logic              bus_busy,
   output logic              cmd_valid,
   output logic [1:0]        cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              cmd_rnw,
   output logic [DATA_W-1:0] cmd_data,
   input  logic              eng_done,
   input  logic              eng_ack,
   input  logic [DATA_W-1:0] eng_rdata
);
   initial begin
      if (ADDR_W != 7) $fatal(1, "i2c_xfer_seq: only 7-bit addressing is built");
      if (DATA_W != 8) $fatal(1, "i2c_xfer_seq: bytes are 8 bits");
   end

   logic cnt_zero, cnt_load, cnt_dec;
   logic tx_pop, tx_empty, tx_full;
   logic rx_push, rx_empty, rx_full;
   logic flush;

   i2cs_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .cnt_zero  (cnt_zero),
      .tx_empty  (tx_empty),
      .rx_full   (rx_full),
      .eng_done  (eng_done),
      .eng_ack   (eng_ack),
      .ctrl_q    (ctrl_q),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cnt_load  (cnt_load),
      .cnt_dec   (cnt_dec),
      .tx_pop    (tx_pop),
      .rx_push   (rx_push),
      .flush     (flush),
      .nack_q    (nack_flag),
      .ardy_q    (ardy_flag),
      .busy_q    (bus_busy)
   );

   i2cs_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_wr  (cnt_wr),
      .prog_val (cnt_wdata),
      .load     (cnt_load),
      .dec      (cnt_dec),
      .cnt_q    (work_cnt),
      .zero     (cnt_zero)
   );

   i2cs_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (tx_push),
      .din   (tx_byte),
      .pop   (tx_pop),
      .dout  (cmd_data),
      .empty (tx_empty),
      .full  (tx_full)
   );

   i2cs_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (rx_push),
      .din   (eng_rdata),
      .pop   (rx_pop),
      .dout  (rx_byte),
      .empty (rx_empty),
      .full  (rx_full)
   );

   assign cmd_addr = tgt_addr;
   assign cmd_rnw  = !ctrl_q[CB_TRX];
   assign rrdy     = !rx_empty;
   assign xrdy     = ctrl_q[CB_EN] && bus_busy && ctrl_q[CB_TRX] && !nack_flag &&
                     (ctrl_q[CB_RPT] || !cnt_zero) && !tx_full;

   AST_RX_ONLY_WITH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_RECV) |-> !rx_full); // R6
   AST_SEND_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SEND) |-> !tx_empty); // R4
endmodule

// File: tb/i2c_xfer_seq_test.sv
module i2c_xfer_seq_test;
   localparam logic [15:0] F_EN = 16'h8000, F_MST = 16'h0400, F_TRX = 16'h0200,
                           F_RPT = 16'h0004, F_STP = 16'h0002, F_STT = 16'h0001;

   // {trx, 7'b0, count, nack_at (FF none, 00 address), bytes moved}
   localparam logic [31:0] VECS [9] = '{
      32'h8003FF03, 32'h80020101, 32'h80040000, 32'h0003FF03, 32'h0001FF01,
      32'h8001FF01, 32'h80040303, 32'h0004FF04, 32'h8000FF00 };

   logic        clk = 0, rst_n = 0;
   logic        ctl_wr = 0, cnt_wr = 0, tx_push = 0, rx_pop = 0;
   logic [15:0] ctl_wdata = '0, cnt_wdata = '0;
   logic [6:0]  tgt_addr = 7'h5A;
   logic [7:0]  tx_byte = '0, rx_byte, cmd_data, eng_rdata;
   logic [15:0] ctrl_q, work_cnt;
   logic        nack_flag, ardy_flag, xrdy, rrdy, bus_busy, cmd_valid, cmd_rnw;
   logic [1:0]  cmd_op;
   logic [6:0]  cmd_addr;
   logic        eng_done, eng_ack;

   logic        done_q = 0, ack_q = 0, hold = 0, force_done = 0, eng_clr = 0;
   logic [1:0]  lat = 0;
   int          nack_at = -1;
   int          n_start = 0, n_send = 0, n_recv = 0, n_stop = 0;
   logic [6:0]  st_addr = '0;
   logic        st_rnw = 0;
   logic [7:0]  sent_log [8];
   logic [7:0]  rdata_q = '0;
   int          errors = 0, checks = 0;

   always #10 clk = ~clk;

   assign eng_done  = done_q | force_done;
   assign eng_ack   = force_done ? 1'b0 : ack_q;
   assign eng_rdata = rdata_q;

   i2c_xfer_seq uut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .tgt_addr(tgt_addr),
      .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
      .ctrl_q(ctrl_q), .work_cnt(work_cnt), .nack_flag(nack_flag),
      .ardy_flag(ardy_flag), .xrdy(xrdy), .rrdy(rrdy), .bus_busy(bus_busy),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_rnw(cmd_rnw), .cmd_data(cmd_data), .eng_done(eng_done),
      .eng_ack(eng_ack), .eng_rdata(eng_rdata));

   // Byte engine model: completes each command three cycles after it appears.
   always @(posedge clk) begin
      done_q <= 1'b0;
      if (eng_clr) begin
         n_start <= 0; n_send <= 0; n_recv <= 0; n_stop <= 0; lat <= 0;
      end else if (cmd_valid && !done_q && !hold) begin
         if (lat == 2'd2) begin
            lat    <= 0;
            done_q <= 1'b1;
            case (cmd_op)
               2'd0: begin n_start <= n_start + 1; ack_q <= (nack_at != 0);
                           st_addr <= cmd_addr; st_rnw <= cmd_rnw; end
               2'd1: begin sent_log[n_send[2:0]] <= cmd_data;
                           ack_q <= ((n_send + 1) != nack_at); n_send <= n_send + 1; end
               2'd2: begin rdata_q <= 8'hA0 + 8'(n_recv); n_recv <= n_recv + 1; end
               default: n_stop <= n_stop + 1;
            endcase
         end else lat <= lat + 2'd1;
      end else if (!cmd_valid) lat <= 0;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      @(negedge clk); ctl_wr = 1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 0;
   endtask

   task automatic wr_cnt(input logic [15:0] v);
      @(negedge clk); cnt_wr = 1; cnt_wdata = v;
      @(negedge clk); cnt_wr = 0;
   endtask

   task automatic push_byte(input logic [7:0] b);
      @(negedge clk); tx_push = 1; tx_byte = b;
      @(negedge clk); tx_push = 0;
   endtask

   task automatic pop_check(input string req, input logic [7:0] exp);
      @(negedge clk); chk(req, rx_byte, exp); rx_pop = 1;
      @(negedge clk); rx_pop = 0;
   endtask

   task automatic clear_engine();
      @(negedge clk); eng_clr = 1;
      @(negedge clk); eng_clr = 0;
   endtask

   task automatic settle();
      for (int k = 0; k < 300 && ctrl_q[1:0] != 2'b00; k++) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   task automatic run_vec(input logic [31:0] v);
      logic trx; int cnt, nat, expn;
      trx = v[31]; cnt = v[23:16]; nat = v[15:8]; expn = v[7:0];
      wr_ctl(16'h0000);
      clear_engine();
      nack_at = (nat == 255) ? -1 : nat;
      if (trx) for (int i = 0; i < cnt; i++) push_byte(8'h30 + 8'(i));
      wr_cnt(16'(cnt));
      wr_ctl(F_EN | F_MST | F_STP | F_STT | (trx ? F_TRX : 16'h0));
      settle();
      chk("R2 start issued", n_start, 1);
      chk("R2 start address", st_addr, 7'h5A);
      chk("R2 start direction", st_rnw, !trx);
      chk(trx ? "R4/R8 bytes sent" : "R6 bytes received", trx ? n_send : n_recv, expn);
      chk("R3/R8 nack flag", nack_flag, nat != 255);
      chk("R5 access ready", ardy_flag, nat == 255);
      chk("R5 master bit", ctrl_q[10], nat != 255);
      chk("R3/R5 stop count", n_stop, (nat == 0) ? 0 : 1);
      chk("R5 count reloaded", work_cnt, cnt);
      if (trx) begin
         for (int i = 0; i < expn; i++) chk("R4 send order", sent_log[i], 8'h30 + 8'(i));
      end else begin
         chk("R6 rrdy", rrdy, expn != 0);
         for (int i = 0; i < expn; i++) pop_check("R6 receive order", 8'hA0 + 8'(i));
         chk("R6 drained", rrdy, 0);
      end
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 ctrl", ctrl_q, 0);
      chk("R11 cmd_valid", cmd_valid, 0);
      chk("R11 flags", {nack_flag, ardy_flag, xrdy, rrdy, bus_busy}, 0);
      chk("R11 count", work_cnt, 0);

      // R1 mask, R9 start ignored while disabled
      wr_ctl(16'h7FFF);
      chk("R1 masked control", ctrl_q, 16'h4F87);
      repeat (4) @(negedge clk);
      chk("R9 no command while disabled", cmd_valid, 0);
      chk("R9 bus idle while disabled", bus_busy, 0);

      for (int v = 0; v < 9; v++) run_vec(VECS[v]);

      // R10 transmit ready, R5 completion without stop then late stop
      wr_ctl(16'h0000); clear_engine(); nack_at = -1;
      wr_cnt(16'd3);
      wr_ctl(F_EN | F_MST | F_TRX | F_STT);
      settle();
      chk("R10 xrdy when data needed", xrdy, 1);
      chk("R4 no send without data", n_send, 0);
      for (int i = 0; i < 3; i++) push_byte(8'h50 + 8'(i));
      repeat (30) @(negedge clk);
      chk("R4 sends", n_send, 3);
      chk("R5 ardy", ardy_flag, 1);
      chk("R5 master cleared", ctrl_q[10], 0);
      chk("R10 xrdy low at zero count", xrdy, 0);
      chk("R5 no stop without stop bit", n_stop, 0);
      chk("R5 bus held", bus_busy, 1);
      wr_ctl(F_EN | F_TRX | F_STP);
      settle();
      chk("R5 late stop issued", n_stop, 1);
      chk("R5 bus released", bus_busy, 0);

      // R7 repeat mode receive ignores count, R6 buffer bound
      wr_ctl(16'h0000); clear_engine();
      wr_cnt(16'd2);
      wr_ctl(F_EN | F_MST | F_RPT | F_STT);
      repeat (60) @(negedge clk);
      chk("R7/R6 receives up to buffer depth", n_recv, 4);
      chk("R7 count untouched", work_cnt, 2);
      chk("R6 rrdy", rrdy, 1);
      chk("R7 no completion", ardy_flag, 0);
      wr_ctl(F_EN | F_MST | F_RPT | F_STP);
      settle();
      chk("R7 stop at once", n_stop, 1);
      chk("R7 no extra receive", n_recv, 4);

      // R6 receive stalls on a full buffer and resumes after pops
      wr_ctl(16'h0000); clear_engine();
      wr_cnt(16'd6);
      wr_ctl(F_EN | F_MST | F_STP | F_STT);
      repeat (60) @(negedge clk);
      chk("R6 stall at depth", n_recv, 4);
      chk("R4 count decremented", work_cnt, 2);
      chk("R6 no stop yet", n_stop, 0);
      pop_check("R6 first byte", 8'hA0);
      pop_check("R6 second byte", 8'hA1);
      repeat (40) @(negedge clk);
      chk("R6 resumed", n_recv, 6);
      chk("R5 ardy after resume", ardy_flag, 1);
      chk("R5 stop after resume", n_stop, 1);
      chk("R5 reload after stop", work_cnt, 6);

      // R9 done strobe ignored when disabled
      wr_ctl(16'h0000); clear_engine(); hold = 1;
      push_byte(8'h11);
      wr_cnt(16'd1);
      wr_ctl(F_EN | F_MST | F_TRX | F_STT);
      repeat (3) @(negedge clk);
      chk("R2 start pending", {cmd_valid, cmd_op}, 3'b100);
      wr_ctl(16'h0000);
      chk("R9 command dropped", cmd_valid, 0);
      @(negedge clk); force_done = 1;
      @(negedge clk); force_done = 0;
      repeat (2) @(negedge clk);
      chk("R9 nack ignored", nack_flag, 0);
      chk("R9 bus idle", bus_busy, 0);
      chk("R9 ctrl unchanged", ctrl_q, 0);
      hold = 0;
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule